// File: doc/BRIEF.md
# Audio DMA Channel Control Engine

This block is the control and position-tracking side of one direction of an audio ring-buffer DMA. Software programs it through a small word-addressed read/write port with 32-bit data. It holds a control word, a status word, the sample-rate multiplier, the period geometry, a 64-bit buffer base address and a bytes-per-channel value. A datapath pulses a strobe for every byte it moves. The block turns these strobes into a byte offset inside a ring buffer that is divided into equal periods.

Each time the offset reaches the end of a period, the block sets a sticky completion flag, which software clears by writing 1. An interrupt line shows the flag gated by its enable. Software can also request a soft reset. The reset bit stays visible for a fixed number of cycles and then clears itself. When it clears, the channel's progress state is returned to zero and the programmed configuration is kept.

Top module: `aud_chan_ctrl`

## Requirements
- R1: After rst_ni is released, every mapped word reads 0 and irq_o is 0.
- R2: These words read back what was last written to them: the sample-rate multiplier (word 6), the period geometry (word 7, period count in bits 31:16, period bytes in bits 15:0), the buffer base low and high halves (words 8 and 9), and bytes per channel (word 17). The control word (word 4) reads back only its stored fields: run enable in bit 0, completion interrupt enable in bit 13, timeout interrupt enable in bit 14, sample-width code in bits 18:16 (0=8, 1=16, 2=20, 3=24, 4=32 bits) and active channels in bits 22:19. All its other bits read 0 while no reset is in progress.
- R3: Writes to an unmapped word, to the position word (word 10) or to read-only status bits have no effect. A read of an unmapped word returns 0.
- R4: While run enable is 1 and no soft reset is in progress, each cycle with byte_stb_i high advances the offset by one. Word 10 returns the offset.
- R5: Clearing run enable freezes the offset. Setting it again resumes from the frozen value.
- R6: The offset wraps to 0 on the strobe that would make it equal to period count times period bytes.
- R7: The completion flag (status bit 31) is set on each strobe that completes a period, including the strobe that wraps the buffer.
- R8: Writing 1 to status bit 31 clears the flag and writing 0 leaves it set. If a period completes in the same cycle as the clearing write, the flag ends up set.
- R9: irq_o is high exactly when the completion flag and the completion interrupt enable are both 1.
- R10: Writing 1 to control bit 1 starts a soft reset. The bit reads 1 for the RST_CYC cycles after the write and then 0. Strobes have no effect during this time. At the end, the offset, run enable and the completion flag are cleared, and all other registers keep their values.
- R11: Status bit 29 reads the current level of chsts_avail_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid during a read request |
| byte_stb_i | input | 1 | One byte moved by the datapath |
| chsts_avail_i | input | 1 | Channel-status data available |
| irq_o | output | 1 | Period-complete interrupt |

## Verification
Two pairs of events can land in the same clock edge. The first pair is a period completion and a software write that clears the completion flag. The bench lines up a strobe on the last byte of a period with a write of 1 to status bit 31, then reads status to confirm that the flag survived and that the offset moved. The second pair is a strobe and the soft reset. The bench holds the strobe high across the whole reset window and confirms that the offset ends at 0 with run enable cleared.

// File: rtl/aud_chan_pkg.sv
package aud_chan_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned SZ_W   = 16;
  localparam int unsigned CH_W   = 4;

  // word indices
  localparam int unsigned W_CTRL = 4;
  localparam int unsigned W_STAT = 5;
  localparam int unsigned W_FSM  = 6;
  localparam int unsigned W_PCFG = 7;
  localparam int unsigned W_BLO  = 8;
  localparam int unsigned W_BHI  = 9;
  localparam int unsigned W_XCNT = 10;
  localparam int unsigned W_BPC  = 17;

  // control bit positions
  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_SRST  = 1;
  localparam int unsigned C_IOCIE = 13;
  localparam int unsigned C_TOIE  = 14;
  localparam int unsigned C_WID   = 16;
  localparam int unsigned C_CH    = 19;

  // status bit positions
  localparam int unsigned S_CHS = 29;
  localparam int unsigned S_IOC = 31;

  typedef enum logic [2:0] {
    WID_8  = 3'd0,
    WID_16 = 3'd1,
    WID_20 = 3'd2,
    WID_24 = 3'd3,
    WID_32 = 3'd4
  } wid_e;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    wid_e            wid;
    logic            toie;
    logic            iocie;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/aud_chan_rst_seq.sv
module aud_chan_rst_seq #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic fin_o
);
  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(RST_CYC - 1);
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == '0);

  // R10
  rst_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == CW'(RST_CYC - 1));

  // R10
  rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/aud_chan_pos.sv
module aud_chan_pos
  import aud_chan_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            clr_i,
  input  logic [CNT_W-1:0] pcount_i,
  input  logic [SZ_W-1:0]  psize_i,
  output logic [DW-1:0]    off_o,
  output logic             per_evt_o
);
  localparam int unsigned LW = CNT_W + SZ_W;

  logic [LW-1:0]   off_q;
  logic [SZ_W-1:0] per_q;
  logic [LW-1:0]   limit;
  logic [LW:0]     off_inc;
  logic [SZ_W:0]   per_inc;
  logic            buf_end, per_end;

  assign limit   = LW'(pcount_i) * LW'(psize_i);
  assign off_inc = {1'b0, off_q} + 1'b1;
  assign per_inc = {1'b0, per_q} + 1'b1;
  assign buf_end = off_inc >= {1'b0, limit};
  assign per_end = per_inc >= {1'b0, psize_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      per_q <= '0;
    end else if (clr_i) begin
      off_q <= '0;
      per_q <= '0;
    end else if (adv_i) begin
      off_q <= buf_end ? '0 : off_inc[LW-1:0];
      per_q <= (buf_end || per_end) ? '0 : per_inc[SZ_W-1:0];
    end
  end

  assign off_o     = DW'(off_q);
  assign per_evt_o = adv_i && !clr_i && (per_end || buf_end);

  // R4 R5
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(off_q));

  // R6
  off_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (off_q == $past(off_q) + 1'b1) || (off_q == '0));

  // R10
  off_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> off_q == '0 && per_q == '0);
endmodule

// File: rtl/aud_chan_regs.sv
module aud_chan_regs
  import aud_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              per_evt_i,
  input  logic [DW-1:0]     off_i,
  input  logic              chsts_i,
  output ctrl_t             ctrl_o,
  output logic              srst_start_o,
  output logic [CNT_W-1:0]  pcount_o,
  output logic [SZ_W-1:0]   psize_o,
  output logic              irq_o
);
  ctrl_t         ctrl_q;
  logic          flag_q;
  logic [DW-1:0] fsm_q, pcfg_q, blo_q, bhi_q, bpc_q;
  logic          wr, rd;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned w);
    return a == ADDR_W'(w);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      fsm_q  <= '0;
      pcfg_q <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      bpc_q  <= '0;
    end else begin
      if (wr && hit(addr_i, W_CTRL)) begin
        ctrl_q.en    <= wdata_i[C_EN];
        ctrl_q.iocie <= wdata_i[C_IOCIE];
        ctrl_q.toie  <= wdata_i[C_TOIE];
        ctrl_q.wid   <= wid_e'(wdata_i[C_WID +: 3]);
        ctrl_q.ch    <= wdata_i[C_CH +: CH_W];
      end
      // reset completion overrides a concurrent enable write
      if (fin_i) ctrl_q.en <= 1'b0;
      if (wr && hit(addr_i, W_FSM))  fsm_q  <= wdata_i;
      if (wr && hit(addr_i, W_PCFG)) pcfg_q <= wdata_i;
      if (wr && hit(addr_i, W_BLO))  blo_q  <= wdata_i;
      if (wr && hit(addr_i, W_BHI))  bhi_q  <= wdata_i;
      if (wr && hit(addr_i, W_BPC))  bpc_q  <= wdata_i;
    end
  end

  // period event beats a same-cycle clear; reset completion beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          flag_q <= 1'b0;
    else if (fin_i)                                       flag_q <= 1'b0;
    else if (per_evt_i)                                   flag_q <= 1'b1;
    else if (wr && hit(addr_i, W_STAT) && wdata_i[S_IOC]) flag_q <= 1'b0;
  end

  assign srst_start_o = wr && hit(addr_i, W_CTRL) && wdata_i[C_SRST] && !busy_i;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit(addr_i, W_CTRL)) begin
        rdata_o[C_EN]          = ctrl_q.en;
        rdata_o[C_SRST]        = busy_i;
        rdata_o[C_IOCIE]       = ctrl_q.iocie;
        rdata_o[C_TOIE]        = ctrl_q.toie;
        rdata_o[C_WID +: 3]    = ctrl_q.wid;
        rdata_o[C_CH +: CH_W]  = ctrl_q.ch;
      end
      if (hit(addr_i, W_STAT)) begin
        rdata_o[S_IOC] = flag_q;
        rdata_o[S_CHS] = chsts_i;
      end
      if (hit(addr_i, W_FSM))  rdata_o = fsm_q;
      if (hit(addr_i, W_PCFG)) rdata_o = pcfg_q;
      if (hit(addr_i, W_BLO))  rdata_o = blo_q;
      if (hit(addr_i, W_BHI))  rdata_o = bhi_q;
      if (hit(addr_i, W_XCNT)) rdata_o = off_i;
      if (hit(addr_i, W_BPC))  rdata_o = bpc_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign pcount_o = pcfg_q[16 +: CNT_W];
  assign psize_o  = pcfg_q[0 +: SZ_W];
  assign irq_o    = flag_q && ctrl_q.iocie;

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_evt_i && !fin_i) |=> flag_q);

  // R10
  fin_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> !flag_q && !ctrl_q.en);

  // R10
  cfg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !wr) |=> $stable(pcfg_q) && $stable(fsm_q) && $stable(ctrl_q.iocie));

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> flag_q && ctrl_q.iocie);
endmodule

// File: rtl/aud_chan_ctrl.sv
module aud_chan_ctrl
  import aud_chan_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              byte_stb_i,
  input  logic              chsts_avail_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             busy, fin, srst_start, adv, per_evt;
  logic [CNT_W-1:0] pcount;
  logic [SZ_W-1:0]  psize;
  logic [DW-1:0]    off;

  assign adv = byte_stb_i && ctrl.en && !busy;

  aud_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .busy_i       (busy),
    .fin_i        (fin),
    .per_evt_i    (per_evt),
    .off_i        (off),
    .chsts_i      (chsts_avail_i),
    .ctrl_o       (ctrl),
    .srst_start_o (srst_start),
    .pcount_o     (pcount),
    .psize_o      (psize),
    .irq_o        (irq_o)
  );

  aud_chan_rst_seq #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .busy_o  (busy),
    .fin_o   (fin)
  );

  aud_chan_pos u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .clr_i     (fin),
    .pcount_i  (pcount),
    .psize_i   (psize),
    .off_o     (off),
    .per_evt_o (per_evt)
  );

  // R4
  busy_no_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !per_evt);
endmodule

// File: tb/aud_chan_ctrl_tb.sv
module aud_chan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, stb = 1'b0, chs = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  aud_chan_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .byte_stb_i(stb),
    .chsts_avail_i(chs), .irq_o(irq)
  );

  // {is_r3, addr, wdata, expected}
  localparam int NV = 11;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 6'd6,  32'h0000_0100, 32'h0000_0100},
    {1'b0, 6'd7,  32'h0002_00C0, 32'h0002_00C0},
    {1'b0, 6'd8,  32'hDEAD_BEC0, 32'hDEAD_BEC0},
    {1'b0, 6'd9,  32'h0000_0012, 32'h0000_0012},
    {1'b0, 6'd17, 32'h0000_0060, 32'h0000_0060},
    {1'b0, 6'd4,  32'hFFFF_E000, 32'h007F_6000},
    {1'b0, 6'd4,  32'h0000_0000, 32'h0000_0000},
    {1'b1, 6'd3,  32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 6'd10, 32'h0000_0055, 32'h0000_0000},
    {1'b1, 6'd5,  32'h5FFF_FFFF, 32'h0000_0000},
    {1'b1, 6'd31, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); stb = 1'b1;
    repeat (n) @(negedge clk);
    stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][69:64], d);
      check("R1 reset read", d, 32'h0);
    end
    rd(6'd10, d); check("R1 offset", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R3 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], d);
      check(VEC[i][70] ? "R3 ignored write" : "R2 readback", d, VEC[i][31:0]);
    end
    rd(6'd6, d); check("R3 fs mult kept", d, 32'h0000_0100);

    // R4 advance, geometry 2 x 192
    wr(6'd4, 32'h0000_2001);
    pulse(10);
    rd(6'd10, d); check("R4 offset", d, 32'd10);
    // R5 pause and resume
    wr(6'd4, 32'h0000_2000);
    pulse(5);
    rd(6'd10, d); check("R5 paused", d, 32'd10);
    wr(6'd4, 32'h0000_2001);
    pulse(181);
    rd(6'd10, d); check("R5 resumed", d, 32'd191);
    rd(6'd5, d);  check("R7 no flag yet", d, 32'h0);
    pulse(1);
    rd(6'd10, d); check("R7 offset 192", d, 32'd192);
    rd(6'd5, d);  check("R7 flag set", d, 32'h8000_0000);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(6'd4, 32'h0000_0001);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(6'd5, d); check("R9 flag kept", d, 32'h8000_0000);
    wr(6'd5, 32'h0);
    rd(6'd5, d); check("R8 write 0 keeps", d, 32'h8000_0000);
    wr(6'd5, 32'h8000_0000);
    rd(6'd5, d); check("R8 w1c", d, 32'h0);
    wr(6'd4, 32'h0000_2001);

    // R6 wrap
    pulse(191);
    rd(6'd10, d); check("R6 offset 383", d, 32'd383);
    pulse(1);
    rd(6'd10, d); check("R6 wrap", d, 32'd0);
    rd(6'd5, d);  check("R7 flag at wrap", d, 32'h8000_0000);
    wr(6'd5, 32'h8000_0000);

    // R8 collision: period end with clearing write
    pulse(191);
    @(negedge clk); stb = 1'b1; req = 1'b1; we = 1'b1; addr = 6'd5; wdata = 32'h8000_0000;
    @(negedge clk); stb = 1'b0; req = 1'b0; we = 1'b0;
    rd(6'd5, d);  check("R8 set wins", d, 32'h8000_0000);
    rd(6'd10, d); check("R8 offset moved", d, 32'd192);

    // R10 soft reset with strobe held high
    @(negedge clk); stb = 1'b1; req = 1'b1; we = 1'b1; addr = 6'd4; wdata = 32'h0000_2003;
    @(negedge clk); we = 1'b0;
    for (int i = 0; i < 5; i++) begin
      req = 1'b1; addr = 6'd4;
      #1 check("R10 reset bit", {31'b0, rdata[1]}, (i < 4) ? 32'h1 : 32'h0);
      req = 1'b0;
      @(negedge clk);
    end
    stb = 1'b0;
    rd(6'd10, d); check("R10 offset cleared", d, 32'h0);
    rd(6'd4, d);  check("R10 ctrl", d, 32'h0000_2000);
    rd(6'd5, d);  check("R10 flag cleared", d, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    rd(6'd7, d);  check("R10 geometry kept", d, 32'h0002_00C0);
    rd(6'd6, d);  check("R10 fs mult kept", d, 32'h0000_0100);

    // R11 channel-status level
    chs = 1'b1;
    rd(6'd5, d); check("R11 chsts high", d, 32'h2000_0000);
    chs = 1'b0;
    rd(6'd5, d); check("R11 chsts low", d, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule